// File: doc/BRIEF.md
# SM3 Message Word Expander

This block feeds the round core of an SM3 hash engine with message words. A 512-bit message block is captured with a load strobe and split into sixteen 32-bit words. The block then presents two words for every round index j from 0 to 63: W_j and W_{j+4}. These are the two operands the round core combines in its W_j XOR W_{j+4} term. The block does no compression and no padding. It only prepares the message schedule.

The 68 schedule words are never stored together. A 16-slot rolling window holds the live words, and each slot is addressed modulo 16. Each time the round index advances, at most one new word is computed from five older window words and written over the oldest one. Generation runs five words ahead of the round index, so W_{j+4} is already held when round j is shown. The round core raises an advance input for each round it consumes. An abort input frees the block for a new load at any time.

Top module: `sm3x_expander`

## Requirements
- R1: After a synchronous active-low reset, `act_o` is 0, `rnd_o` is 0, and both word outputs are 0.
- R2: A load while idle (`act_o` = 0) captures `block_i`. In the next cycle `act_o` is 1 and `rnd_o` is 0. Word i of the block is `block_i[511-32*i -: 32]`, so the earliest byte of each word is its most significant byte.
- R3: While `act_o` is 1, `w_j_o` shows W_j and `w_j4_o` shows W_{j+4}, where j is the current `rnd_o`. Each advance raises `rnd_o` by exactly 1.
- R4: Words W_16 to W_67 follow W_n = P1(W_{n-16} ^ W_{n-9} ^ rol(W_{n-3},15)) ^ rol(W_{n-13},7) ^ W_{n-6}, where P1(x) = x ^ rol(x,15) ^ rol(x,23) and rol is a 32-bit left rotation.
- R5: With no advance, load or abort, `rnd_o` and both word outputs hold their values.
- R6: An advance at round 63 drops `act_o` to 0. `rnd_o` stays 63 and the outputs keep W_63 and W_67. Any later advance while idle changes nothing.
- R7: A load while `act_o` is 1 and `abort_i` is 0 is ignored. The round index and both outputs are unaffected.
- R8: An abort alone drops `act_o` to 0 in the next cycle. An abort together with a load starts the new block at once, with round 0 of that block in the next cycle.
- R9: After a block has finished at round 63, a new load is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Capture `block_i` as a new message block |
| block_i | input | 512 | Message block, first byte in bits 511:504 |
| adv_i | input | 1 | Round core consumed the current round |
| abort_i | input | 1 | Abandon the current block |
| w_j_o | output | 32 | Schedule word W_j for the current round |
| w_j4_o | output | 32 | Schedule word W_{j+4} for the current round |
| rnd_o | output | 6 | Current round index j |
| act_o | output | 1 | A block is being walked |

## Verification
A load can land in the same cycle as an abort, and a load can also arrive while a block is still being walked. Priority decides the outcome in both cases.

The bench starts a block and walks it to round 40, then raises load and abort together with a different block. It expects the next cycle to show round 0 of the new block, and every round of that block is compared against a schedule computed in the bench. It also pulses load at round 5 without abort and judges from the outputs that the old block kept its round and words.

// File: rtl/sm3x_pkg.sv
`timescale 1ns/1ps
// Shared word type and bit-mixing helpers for the SM3 message expander.
// Assumes 32-bit words, which the hash fixes.
package sm3x_pkg;
    localparam int WORD_W = 32;
    localparam int ROT_A  = 15;
    localparam int ROT_B  = 23;
    localparam int ROT_C  = 7;

    typedef logic [WORD_W-1:0] word_t;

    // Left rotation of a word by s positions (0 < s < WORD_W).
    function automatic word_t rotl(input word_t x, input int unsigned s);
        return (x << s) | (x >> (WORD_W - s));
    endfunction

    // Permutation used by the schedule recurrence.
    function automatic word_t perm1(input word_t x);
        return x ^ rotl(x, ROT_A) ^ rotl(x, ROT_B);
    endfunction
endpackage

// File: rtl/sm3x_unpack.sv
`timescale 1ns/1ps
// Splits a flat message block into words. The first byte lands in the top
// bits of word 0, which gives big-endian words. Pure wiring.
module sm3x_unpack #(
    parameter int WIN = 16
) (
    input  logic [WIN*sm3x_pkg::WORD_W-1:0]   block_i,
    output logic [WIN-1:0][sm3x_pkg::WORD_W-1:0] words_o
);
    localparam int W = sm3x_pkg::WORD_W;

    // One slice per word; word 0 comes from the most significant end.
    for (genvar i = 0; i < WIN; i++) begin : g_word
        assign words_o[i] = block_i[(WIN-1-i)*W +: W];
    end
endmodule

// File: rtl/sm3x_mix.sv
`timescale 1ns/1ps
// Computes schedule word W_n from the rolling window. Slot k holds the word
// whose index is k modulo WIN. Assumes WIN is 16, as the recurrence needs.
module sm3x_mix #(
    parameter  int WIN   = 16,
    localparam int IDX_W = $clog2(WIN)
) (
    input  logic [WIN-1:0][sm3x_pkg::WORD_W-1:0] win_i,
    input  logic [IDX_W-1:0]                     n_i,
    output sm3x_pkg::word_t                      word_o
);
    import sm3x_pkg::*;

    localparam int BACK_A = 16;
    localparam int BACK_B = 9;
    localparam int BACK_C = 3;
    localparam int BACK_D = 13;
    localparam int BACK_E = 6;

    logic [IDX_W-1:0] ia, ib, ic, id, ie;

    // Modular slot addresses of the five source words.
    always_comb begin
        ia = n_i - IDX_W'(BACK_A);
        ib = n_i - IDX_W'(BACK_B);
        ic = n_i - IDX_W'(BACK_C);
        id = n_i - IDX_W'(BACK_D);
        ie = n_i - IDX_W'(BACK_E);
    end

    // Recurrence for one new word.
    always_comb begin
        word_o = perm1(win_i[ia] ^ win_i[ib] ^ rotl(win_i[ic], ROT_A))
               ^ rotl(win_i[id], ROT_C) ^ win_i[ie];
    end
endmodule

// File: rtl/sm3x_ctrl.sv
`timescale 1ns/1ps
// Round sequencing. Tracks the round index and the active flag, decides
// whether a load is accepted, and says which window slot receives a new word
// on each advance. Abort and load outrank advance.
module sm3x_ctrl #(
    parameter  int WIN    = 16,
    parameter  int ROUNDS = 64,
    parameter  int LEAD   = 4,
    localparam int RND_W  = $clog2(ROUNDS),
    localparam int IDX_W  = $clog2(WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             adv_i,
    input  logic             abort_i,
    output logic             ld_ok_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [RND_W-1:0] rnd_o,
    output logic             act_o
);
    localparam int LAST      = ROUNDS - 1;
    localparam int FIRST_GEN = WIN - LEAD - 1;

    logic step;

    // Accept decision and word-generation request for this cycle.
    always_comb begin
        ld_ok_o  = load_i && (!act_o || abort_i);
        step     = act_o && adv_i && !abort_i && (rnd_o != RND_W'(LAST));
        wr_en_o  = step && (rnd_o >= RND_W'(FIRST_GEN));
        wr_idx_o = IDX_W'(rnd_o) + IDX_W'(LEAD + 1);
    end

    // Round counter and active flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o <= 1'b0;
            rnd_o <= '0;
        end else if (ld_ok_o) begin
            act_o <= 1'b1;
            rnd_o <= '0;
        end else if (abort_i) begin
            act_o <= 1'b0;
        end else if (act_o && adv_i) begin
            if (rnd_o == RND_W'(LAST)) act_o <= 1'b0;
            else                       rnd_o <= rnd_o + 1'b1;
        end
    end
endmodule

// File: rtl/sm3x_expander.sv
`timescale 1ns/1ps
// SM3 message word expander. It holds a 16-slot rolling window and presents
// W_j and W_{j+4} for the current round j. It writes one new word per advance,
// LEAD+1 indices ahead of the round. It assumes the round core samples the
// outputs in the cycle it raises adv_i.
module sm3x_expander #(
    parameter  int WIN    = 16,
    parameter  int ROUNDS = 64,
    parameter  int LEAD   = 4,
    localparam int RND_W  = $clog2(ROUNDS),
    localparam int IDX_W  = $clog2(WIN)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_i,
    input  logic [WIN*sm3x_pkg::WORD_W-1:0] block_i,
    input  logic                            adv_i,
    input  logic                            abort_i,
    output logic [sm3x_pkg::WORD_W-1:0]     w_j_o,
    output logic [sm3x_pkg::WORD_W-1:0]     w_j4_o,
    output logic [RND_W-1:0]                rnd_o,
    output logic                            act_o
);
    import sm3x_pkg::*;

    logic [WIN-1:0][WORD_W-1:0] win_q;
    logic [WIN-1:0][WORD_W-1:0] words;
    word_t                      new_word;
    logic                       ld_ok, wr_en;
    logic [IDX_W-1:0]           wr_idx;

    sm3x_unpack #(.WIN(WIN)) u_unpack (
        .block_i (block_i),
        .words_o (words)
    );

    sm3x_ctrl #(.WIN(WIN), .ROUNDS(ROUNDS), .LEAD(LEAD)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_i),
        .adv_i    (adv_i),
        .abort_i  (abort_i),
        .ld_ok_o  (ld_ok),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rnd_o    (rnd_o),
        .act_o    (act_o)
    );

    sm3x_mix #(.WIN(WIN)) u_mix (
        .win_i  (win_q),
        .n_i    (wr_idx),
        .word_o (new_word)
    );

    // Window storage: a load fills all slots, an advance replaces the oldest.
    always_ff @(posedge clk) begin
        if (!rst_n)      win_q <= '0;
        else if (ld_ok)  win_q <= words;
        else if (wr_en)  win_q[wr_idx] <= new_word;
    end

    // Output selection by round index, modulo the window size.
    always_comb begin
        w_j_o  = win_q[rnd_o[IDX_W-1:0]];
        w_j4_o = win_q[rnd_o[IDX_W-1:0] + IDX_W'(LEAD)];
    end
endmodule

// File: rtl/sm3x_expander_chk.sv
`timescale 1ns/1ps
// Protocol checker for the expander, attached through bind. It checks round
// sequencing, holding, the end of a block and the priority of load and abort.
module sm3x_expander_chk #(
    parameter int RND_W = 6,
    parameter int LAST  = 63
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_i,
    input logic             adv_i,
    input logic             abort_i,
    input logic [31:0]      w_j_o,
    input logic [31:0]      w_j4_o,
    input logic [RND_W-1:0] rnd_o,
    input logic             act_o
);
    // R2 / R8: an accepted load starts round 0.
    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (!act_o || abort_i)) |=> (act_o && rnd_o == '0));

    // R3: each advance moves the round by one.
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && adv_i && !abort_i && rnd_o != RND_W'(LAST))
        |=> (act_o && rnd_o == $past(rnd_o) + 1'b1));

    // R5: with no request the view holds.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && !adv_i && !load_i && !abort_i)
        |=> ($stable(rnd_o) && $stable(w_j_o) && $stable(w_j4_o) && act_o));

    // R6: advancing at the last round ends the block with the outputs held.
    p_final_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && adv_i && !abort_i && rnd_o == RND_W'(LAST))
        |=> (!act_o && $stable(rnd_o) && $stable(w_j_o) && $stable(w_j4_o)));

    // R6: an idle block ignores advances.
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_o && !load_i)
        |=> (!act_o && $stable(rnd_o) && $stable(w_j_o) && $stable(w_j4_o)));

    // R7: a load while busy without abort changes nothing.
    p_busy_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_o && load_i && !abort_i && !adv_i)
        |=> ($stable(rnd_o) && $stable(w_j_o) && $stable(w_j4_o)));

    // R8: an abort alone leaves the block idle.
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && !load_i) |=> !act_o);
endmodule

bind sm3x_expander sm3x_expander_chk #(.RND_W(RND_W), .LAST(ROUNDS - 1)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load_i),
    .adv_i   (adv_i),
    .abort_i (abort_i),
    .w_j_o   (w_j_o),
    .w_j4_o  (w_j4_o),
    .rnd_o   (rnd_o),
    .act_o   (act_o)
);

// File: tb/tb_sm3x_expander.sv
`timescale 1ns/1ps
// Directed bench for the SM3 message word expander.
module tb_sm3x_expander;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [511:0] block_i = '0;
    logic         adv_i = 1'b0;
    logic         abort_i = 1'b0;
    logic [31:0]  w_j_o, w_j4_o;
    logic [5:0]   rnd_o;
    logic         act_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0]  ew [0:67];
    logic [511:0] blk_a, blk_b;

    always #4 clk = ~clk;

    sm3x_expander dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .block_i(block_i),
        .adv_i(adv_i), .abort_i(abort_i), .w_j_o(w_j_o), .w_j4_o(w_j4_o),
        .rnd_o(rnd_o), .act_o(act_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int s);
        return (x << s) | (x >> (32 - s));
    endfunction

    // Schedule model written directly from the recurrence (R4).
    task automatic build_exp(input logic [511:0] b);
        for (int i = 0; i < 16; i++) ew[i] = b[511 - 32*i -: 32];
        for (int n = 16; n < 68; n++) begin
            logic [31:0] t;
            t = ew[n-16] ^ ew[n-9] ^ rl(ew[n-3], 15);
            ew[n] = (t ^ rl(t, 15) ^ rl(t, 23)) ^ rl(ew[n-13], 7) ^ ew[n-6];
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_round(input string tag, input int j);
        chk({tag, " w_j"}, w_j_o, ew[j]);
        chk({tag, " w_j4"}, w_j4_o, ew[j+4]);
        chk({tag, " rnd"}, {26'd0, rnd_o}, j);
    endtask

    task automatic step();
        @(negedge clk) adv_i = 1'b1;
        @(negedge clk) adv_i = 1'b0;
    endtask

    task automatic walk(input string tag, input int from, input int to);
        for (int j = from; j < to; j++) begin
            check_round(tag, j);
            step();
        end
    endtask

    task automatic do_load(input logic [511:0] b, input logic ab);
        @(negedge clk) begin load_i = 1'b1; abort_i = ab; block_i = b; end
        @(negedge clk) begin load_i = 1'b0; abort_i = 1'b0; end
    endtask

    // R1: reset state.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 act", {31'd0, act_o}, 0);
        chk("R1 rnd", {26'd0, rnd_o}, 0);
        chk("R1 w_j", w_j_o, 0);
        chk("R1 w_j4", w_j4_o, 0);
    endtask

    // R2 R3 R4 R5 R6: full walk with a hold and the end of the block.
    task automatic t_full_walk();
        build_exp(blk_a);
        do_load(blk_a, 1'b0);
        chk("R2 act", {31'd0, act_o}, 1);
        walk("R3 R4 blkA", 0, 20);
        repeat (3) @(negedge clk);
        check_round("R5 hold", 20);
        walk("R4 blkA", 20, 63);
        check_round("R4 last", 63);
        step();
        chk("R6 act", {31'd0, act_o}, 0);
        check_round("R6 done", 63);
        step();
        check_round("R6 idle adv", 63);
    endtask

    // R9 R7 R8: reload after done, busy load, abort alone.
    task automatic t_busy_and_abort();
        build_exp(blk_b);
        do_load(blk_b, 1'b0);
        chk("R9 act", {31'd0, act_o}, 1);
        walk("R9 blkB", 0, 5);
        do_load(blk_a, 1'b0);
        check_round("R7 busy load", 5);
        walk("R7 blkB", 5, 30);
        @(negedge clk) abort_i = 1'b1;
        @(negedge clk) abort_i = 1'b0;
        chk("R8 abort act", {31'd0, act_o}, 0);
        step();
        chk("R8 idle rnd", {26'd0, rnd_o}, 30);
    endtask

    // R8: load and abort in the same cycle.
    task automatic t_load_abort();
        build_exp(blk_a);
        do_load(blk_a, 1'b0);
        walk("R8 blkA", 0, 40);
        build_exp(blk_b);
        do_load(blk_b, 1'b1);
        chk("R8 restart act", {31'd0, act_o}, 1);
        walk("R8 R4 blkB", 0, 64);
    endtask

    initial begin
        blk_a = '0;
        blk_a[511:480] = 32'h61626380;
        blk_a[31:0] = 32'h00000018;
        for (int i = 0; i < 16; i++)
            blk_b[511 - 32*i -: 32] = (32'h9e3779b9 * (i + 1)) ^ {4{8'(i * 17)}};
        t_reset();
        t_full_walk();
        t_busy_and_abort();
        t_load_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule